// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus cycle at a time for an 8-bit processor whose low address lines also carry data. A request brings a 20-bit address, a memory/I-O select, a read/write select and a write byte. The block steps through the four clock phases T1, T2, T3 and T4. It holds the cycle in wait phases (Tw) for as long as the addressed device keeps READY low.

In T1 the block puts the low address byte on the shared lines and pulses the address-latch strobe, so that external latches can catch it. From T2 on, the shared lines carry data. The block drives the read and write strobes, the memory/I-O select, and a direction/enable pair that steers an external transceiver. A read byte is captured as T4 begins and is returned with a one-cycle done pulse. A reset filter ignores reset requests that are too short.

Top module: `mux_bus_seq`

## Requirements
- R1: A cycle with READY high lasts exactly four clocks (T1, T2, T3, T4). `done` is high only in T4, three clocks after T1, and `busy` is high from T1 through T4.
- R2: `ale` is high in T1 only. In T1 `ad_oe`=1 and `ad_out` equals address bits [7:0]. From T1 to T4, `a_hi` shows address bits [19:8].
- R3: The transfer pair uses this encoding: `den_n`=1 means disconnected; `den_n`=0 with `dt_r`=0 means data flows inward (read); `den_n`=0 with `dt_r`=1 means data flows outward (write). A read enables the path in T2, T3 and Tw. A write enables it from T2 through T4. `dt_r` is 1 for the whole of a write cycle and 0 otherwise.
- R4: `io_m` is 0 for a memory access and 1 for an I/O access, held through T1 to T4. It is 0 when idle.
- R5: `rd_n` (reads) and `wr_n` (writes) are active low, asserted in T2, T3 and Tw only, and never low together.
- R6: `ready` is sampled at the end of T3 and at the end of each Tw. Each low sample inserts exactly one Tw before T4. `ready` has no effect in other phases.
- R7: `rdata` takes the `ad_in` value present at the clock edge that enters T4 and keeps it afterwards. In T4, `rd_n` and `den_n` are already 1.
- R8: In a write, `ad_oe`=1 and `ad_out` equals the write byte from T2 to the end of T4.
- R9: `rst_in` takes effect only after it has stayed high for more than RST_MIN (4) consecutive clocks. It then aborts any cycle and returns the bus to idle: all strobes inactive, `ad_oe`=0, `busy`=0. A pulse of 4 clocks changes nothing.
- R10: A request is accepted only while idle. Changes on the request inputs during a cycle do not alter `a_hi`, `ad_out` or the cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_in | input | 1 | Reset request, filtered by length |
| req_valid | input | 1 | Start a cycle (taken when idle) |
| req_addr | input | 20 | Cycle address |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| ready | input | 1 | Device ready |
| ad_in | input | 8 | Shared lines as seen from outside |
| ad_out | output | 8 | Shared lines driven value |
| ad_oe | output | 1 | Shared lines output enable |
| a_hi | output | 12 | Address bits [19:8] |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Memory/I-O select |
| dt_r | output | 1 | Transceiver direction |
| den_n | output | 1 | Transceiver enable, active low |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Cycle ends (T4) |
| rdata | output | 8 | Captured read byte |

## Verification
Random cycles mix reads and writes, memory and I/O space, addresses and data bytes, and zero to three wait states. The bench checks every output in every phase, which separates a wrong strobe window from a wrong direction code. Directed cases cover long wait runs, which show whether READY is sampled outside T3/Tw, and request inputs changing mid-cycle, which show whether a cycle can be taken over. Reset pulses of four and six clocks separate a filter that is too eager from one that works.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  // Phase successor: idle waits for a start, T3/Tw wait for ready.
  function automatic phase_t next_phase(phase_t p, logic start, logic rdy);
    phase_t n;
    case (p)
      PH_IDLE: n = start ? PH_T1 : PH_IDLE;
      PH_T1:   n = PH_T2;
      PH_T2:   n = PH_T3;
      PH_T3:   n = rdy ? PH_T4 : PH_TW;
      PH_TW:   n = rdy ? PH_T4 : PH_TW;
      PH_T4:   n = PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  // Phases in which the read/write strobe is active.
  function automatic logic strobe_phase(phase_t p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction

  // Phases whose closing edge samples ready.
  function automatic logic ready_phase(phase_t p);
    return (p == PH_T3) || (p == PH_TW);
  endfunction

endpackage

// File: rtl/mbs_rst_filter.sv
module mbs_rst_filter #(
  parameter int RST_MIN = 4
) (
  input  logic clk,
  input  logic rst_in,
  output logic sys_rst
);
  localparam int CNT_TOP = RST_MIN + 1;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_in)
      run_cnt <= '0;
    else if (run_cnt != CNT_W'(CNT_TOP))
      run_cnt <= run_cnt + 1'b1;
  end

  assign sys_rst = (run_cnt == CNT_W'(CNT_TOP));
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   sys_rst,
  input  logic   req_valid,
  input  logic   ready,
  output phase_t phase,
  output logic   start,
  output logic   rdy_slot
);
  assign start    = (phase == PH_IDLE) && req_valid;
  assign rdy_slot = ready_phase(phase);

  always_ff @(posedge clk) begin
    if (sys_rst) phase <= PH_IDLE;
    else         phase <= next_phase(phase, start, ready);
  end
endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              start,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              io_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (sys_rst) begin
      addr_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      io_q    <= req_io;
      wr_q    <= req_wr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst)      rdata_q <= '0;
    else if (capture) rdata_q <= ad_in;
  end
endmodule

// File: rtl/mbs_pin_decode.sv
module mbs_pin_decode
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              io_q,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              dt_r,
  output logic              den_n,
  output logic              busy,
  output logic              done
);
  logic in_cycle, addr_ph, strobe, data_ph;

  always_comb begin
    in_cycle = (phase != PH_IDLE);
    addr_ph  = (phase == PH_T1);
    strobe   = strobe_phase(phase);
    data_ph  = strobe || (phase == PH_T4);

    busy   = in_cycle;
    done   = (phase == PH_T4);
    ale    = addr_ph;
    rd_n   = !(strobe && !wr_q);
    wr_n   = !(strobe && wr_q);
    io_m   = in_cycle && io_q;
    dt_r   = in_cycle && wr_q;
    den_n  = !(wr_q ? data_ph : strobe);
    ad_oe  = addr_ph || (wr_q && data_ph);
    ad_out = addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
    a_hi   = addr_q[ADDR_W-1:DATA_W];
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int RST_MIN = 4,
  localparam int HI_W   = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              dt_r,
  output logic              den_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic              sys_rst;
  phase_t            phase;
  logic              start, rdy_slot, capture;
  logic [ADDR_W-1:0] addr_q;
  logic              io_q, wr_q;
  logic [DATA_W-1:0] wdata_q;

  // Edge that leaves T3/Tw with ready high enters T4.
  assign capture = rdy_slot && ready;

  mbs_rst_filter #(.RST_MIN(RST_MIN)) u_rst (
    .clk(clk), .rst_in(rst_in), .sys_rst(sys_rst)
  );

  mbs_fsm u_fsm (
    .clk(clk), .sys_rst(sys_rst), .req_valid(req_valid), .ready(ready),
    .phase(phase), .start(start), .rdy_slot(rdy_slot)
  );

  mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .sys_rst(sys_rst), .start(start), .capture(capture),
    .req_addr(req_addr), .req_io(req_io), .req_wr(req_wr),
    .req_wdata(req_wdata), .ad_in(ad_in),
    .addr_q(addr_q), .io_q(io_q), .wr_q(wr_q), .wdata_q(wdata_q),
    .rdata_q(rdata)
  );

  mbs_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase(phase), .addr_q(addr_q), .io_q(io_q), .wr_q(wr_q),
    .wdata_q(wdata_q), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .dt_r(dt_r),
    .den_n(den_n), .busy(busy), .done(done)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_in,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic io_m,
  input logic dt_r,
  input logic den_n,
  input logic ad_oe,
  input logic busy,
  input logic done,
  input logic ready,
  input logic rdy_slot
);
  logic [3:0] len;

  always_ff @(posedge clk) begin
    if (ale)                    len <= 4'd1;
    else if (busy && len != 4'hF) len <= len + 4'd1;
  end

  p_len_r1: assert property (@(posedge clk) disable iff (rst_in)
    done |-> (len >= 4'd3));
  p_ale_once_r2: assert property (@(posedge clk) disable iff (rst_in)
    ale |=> !ale);
  p_ale_drive_r2: assert property (@(posedge clk) disable iff (rst_in)
    ale |-> (ad_oe && busy));
  p_rd_dir_r3: assert property (@(posedge clk) disable iff (rst_in)
    !rd_n |-> (!den_n && !dt_r && !ad_oe));
  p_wr_dir_r3: assert property (@(posedge clk) disable iff (rst_in)
    !wr_n |-> (!den_n && dt_r && ad_oe));
  p_io_hold_r4: assert property (@(posedge clk) disable iff (rst_in)
    (busy && !ale) |-> $stable(io_m));
  p_excl_r5: assert property (@(posedge clk) disable iff (rst_in)
    !(!rd_n && !wr_n));
  p_wait_r6: assert property (@(posedge clk) disable iff (rst_in)
    (rdy_slot && !ready) |=> (busy && !done));
  p_go_r6: assert property (@(posedge clk) disable iff (rst_in)
    (rdy_slot && ready) |=> done);
  p_t4_r7: assert property (@(posedge clk) disable iff (rst_in)
    done |-> (rd_n && wr_n && (dt_r || den_n)));
  p_wdrive_r8: assert property (@(posedge clk) disable iff (rst_in)
    (done && dt_r) |-> (ad_oe && !den_n));
  p_idle_r9: assert property (@(posedge clk) disable iff (rst_in)
    !busy |-> (rd_n && wr_n && den_n && !ale && !ad_oe));
endmodule

bind mux_bus_seq mbs_checker u_chk (
  .clk(clk), .rst_in(rst_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .io_m(io_m), .dt_r(dt_r), .den_n(den_n), .ad_oe(ad_oe), .busy(busy),
  .done(done), .ready(ready), .rdy_slot(rdy_slot)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_in, req_valid, req_io, req_wr, ready;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata, ad_in;
  logic [7:0]  ad_out, rdata;
  logic [11:0] a_hi;
  logic        ad_oe, ale, rd_n, wr_n, io_m, dt_r, den_n, busy, done;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rst_in(rst_in), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_wr(req_wr), .req_wdata(req_wdata), .ready(ready),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .dt_r(dt_r), .den_n(den_n),
    .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Phase codes: 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4.
  // Order: ale rd_n wr_n io_m dt_r den_n ad_oe done busy
  function automatic logic [8:0] exp_ctl(int ph, logic wr, logic io);
    logic stb, act;
    stb = (ph >= 2) && (ph <= 4);
    act = (ph != 0);
    return {ph == 1, !(stb && !wr), !(stb && wr), act && io, act && wr,
            !(stb || (wr && ph == 5)), (ph == 1) || (wr && ph >= 2),
            ph == 5, act};
  endfunction

  task automatic chk_phase(input int ph, input logic [19:0] a, input logic io,
                           input logic wr, input logic [7:0] wd);
    chk($sformatf("R1 R2 R3 R4 R5 R8 pins ph=%0d", ph),
        {23'd0, ale, rd_n, wr_n, io_m, dt_r, den_n, ad_oe, done, busy},
        {23'd0, exp_ctl(ph, wr, io)});
    if (ph != 0) chk("R2 a_hi", {20'd0, a_hi}, {20'd0, a[19:8]});
    if (ph == 1) chk("R2 low address on shared lines", {24'd0, ad_out}, {24'd0, a[7:0]});
    if (wr && ph >= 2) chk("R8 write byte on shared lines", {24'd0, ad_out}, {24'd0, wd});
  endtask

  // One full cycle; hold_req keeps a changed request asserted (R10).
  task automatic run_cycle(input logic [19:0] a, input logic io, input logic wr,
                           input logic [7:0] wd, input int waits,
                           input logic [7:0] dev, input logic hold_req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_io = io; req_wr = wr; req_wdata = wd;
    ready = $urandom_range(0, 1);
    @(negedge clk);
    chk_phase(1, a, io, wr, wd);
    if (hold_req) begin
      req_addr = ~a; req_io = ~io; req_wr = ~wr; req_wdata = ~wd;
    end else req_valid = 1'b0;
    ready = $urandom_range(0, 1);   // R6: ignored outside T3/Tw
    @(negedge clk);
    chk_phase(2, a, io, wr, wd);
    @(negedge clk);
    chk_phase(3, a, io, wr, wd);
    ad_in = dev;
    ready = (waits == 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk_phase(4, a, io, wr, wd);
      chk("R6 no done in wait", {31'd0, done}, 32'd0);
      ready = (i == waits - 1);
    end
    @(negedge clk);
    chk_phase(5, a, io, wr, wd);
    if (!wr) chk("R7 captured read byte", {24'd0, rdata}, {24'd0, dev});
    ad_in = ~dev;
    ready = $urandom_range(0, 1);
    @(negedge clk);
    chk_phase(0, a, io, wr, wd);
    if (!wr) chk("R7 read byte held", {24'd0, rdata}, {24'd0, dev});
    if (hold_req) chk("R10 no start before idle", {31'd0, busy}, 32'd0);
    req_valid = 1'b0;
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd424);
    rst_in = 1'b1; req_valid = 1'b0; req_addr = '0; req_io = 1'b0;
    req_wr = 1'b0; req_wdata = '0; ready = 1'b1; ad_in = '0;
    repeat (8) @(negedge clk);
    rst_in = 1'b0;
    @(negedge clk);
    chk_phase(0, '0, 1'b0, 1'b0, '0);   // R9 reset state
    chk("R9 reset state ad_oe", {31'd0, ad_oe}, 32'd0);

    // Directed corners
    run_cycle(20'hFFFF0, 1'b0, 1'b0, 8'h00, 0, 8'hA5, 1'b0);
    run_cycle(20'h00001, 1'b1, 1'b1, 8'h3C, 0, 8'h00, 1'b0);
    run_cycle(20'h12345, 1'b0, 1'b0, 8'h00, 6, 8'h5A, 1'b0);
    run_cycle(20'hABCDE, 1'b1, 1'b1, 8'hC3, 5, 8'h00, 1'b1);
    run_cycle(20'h54321, 1'b0, 1'b0, 8'h00, 1, 8'h81, 1'b1);

    // Random cycles
    for (int n = 0; n < 60; n++)
      run_cycle(20'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                int'($urandom_range(0, 3)), 8'($urandom), 1'($urandom));

    // R9: a four-clock reset pulse during a wait state is ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h0BEEF; req_io = 1'b1; req_wr = 1'b1;
    req_wdata = 8'h77;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); ready = 1'b0;
    @(negedge clk);                      // Tw
    rst_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_in = 1'b0;
    @(negedge clk);
    chk_phase(4, 20'h0BEEF, 1'b1, 1'b1, 8'h77);
    chk("R9 short pulse keeps cycle", {31'd0, busy}, 32'd1);
    // R9: a six-clock pulse aborts the cycle
    rst_in = 1'b1;
    repeat (6) @(negedge clk);
    chk_phase(0, 20'h0, 1'b0, 1'b0, 8'h0);
    chk("R9 long pulse idles bus", {30'd0, busy, ad_oe}, 32'd0);
    rst_in = 1'b0; ready = 1'b1;
    @(negedge clk);
    chk("R9 stays idle after release", {31'd0, busy}, 32'd0);
    run_cycle(20'h80808, 1'b0, 1'b0, 8'h00, 2, 8'hE7, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule